// File: doc/BRIEF.md
# Advanced Load Address Table

This block keeps track of loads that a compiler has hoisted above stores that might alias them. Each such load, when it executes, writes an entry into a small, fully associative table. The entry is keyed by the number of the register the load wrote, and holds the byte address, the access size and a load-kind code. Every store snoops the table and clears any entry whose bytes it touches. A later check names the same register. If a valid entry is found, the speculated value is still good. If no entry is found, the value must be regenerated. A plain reload check only repeats the load. A recovery check sends control to recovery code, so that the dependent work can be redone as well.

Entries can also disappear when the table is full and a new load has to take a slot. Software cannot tell this apart from an aliasing store. The check port is combinational on the table contents as they stand at the start of the cycle. Allocations, snoops and the clear-all input take effect at the next rising edge. A faulting speculative load raises its exception at once, in the same cycle, and does not enter the table.

Top module: `spec_load_table`

## Requirements
- R1: After reset the table is empty, so every check misses until an entry has been allocated.
- R2: An allocate with `alloc_fault`=0 records the register tag, kind, size and address. A check on that tag then asserts `chk_hit` in the same cycle and returns the recorded kind on `chk_kind` and the size code on `chk_size`.
- R3: A check that misses asserts `chk_reissue` when `chk_mode`=0 and `chk_recover` when `chk_mode`=1. At most one of `chk_hit`, `chk_reissue` and `chk_recover` is high, and one of them is high exactly when `chk_valid` is high.
- R4: A size code s covers 2^s bytes (0:1, 1:2, 2:4, 3:8) starting at the address. A snooped store clears every valid entry whose byte range intersects its own, including a partial intersection. A store whose range only abuts an entry leaves it valid.
- R5: An allocate to a tag already present overwrites that entry in place. After that, only the new address range is snooped, and a check returns the new kind and size.
- R6: When no entry matches the tag, the allocate takes the lowest-numbered free entry. When the table is full, it takes the entry under a victim pointer. The pointer starts at 0 and advances by one, wrapping, on each eviction.
- R7: An allocate with `alloc_fault`=1 raises `alloc_exc` in the same cycle and leaves the table unchanged.
- R8: A check, whether it hits or misses, does not change the table, so repeated checks of a live entry keep hitting.
- R9: `flush_all` clears every entry. An allocate in the same cycle still leaves its new entry valid.
- R10: A store counts as older than an allocate in the same cycle. The new entry survives even if the store overlaps it, while other overlapping entries are cleared.
- R11: A check sees the table as it was before the same cycle's store, allocate or flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_all | input | 1 | Invalidate every entry |
| alloc_valid | input | 1 | Speculative load executes this cycle |
| alloc_reg | input | REG_W | Destination register tag |
| alloc_size | input | 2 | Access size code (2^code bytes) |
| alloc_kind | input | KIND_W | Load kind code |
| alloc_addr | input | ADDR_W | Byte address of the load |
| alloc_fault | input | 1 | Load faulted; raise exception, do not record |
| st_valid | input | 1 | Store snoop this cycle |
| st_addr | input | ADDR_W | Store byte address |
| st_size | input | 2 | Store size code |
| chk_valid | input | 1 | Check this cycle |
| chk_reg | input | REG_W | Register tag to check |
| chk_mode | input | 1 | 0 reload on miss, 1 branch to recovery on miss |
| chk_hit | output | 1 | Entry present, speculation holds |
| chk_reissue | output | 1 | Miss, repeat the load |
| chk_recover | output | 1 | Miss, run recovery code |
| chk_kind | output | KIND_W | Kind of the hit entry (0 on miss) |
| chk_size | output | 2 | Size code of the hit entry (0 on miss) |
| alloc_exc | output | 1 | Immediate exception from a faulting allocate |

## Verification
The directed part checks each corner on its own terms:
- Stores that abut an entry are told apart from stores that partially overlap it.
- A re-allocation to the same tag moves which address range is snooped.
- Filling the table and then allocating more entries shows the free-slot preference separately from the round-robin victim choice.
- Allocates that coincide in one cycle with a store or a flush show the age ordering.
- A check in the same cycle as a killing store tells a pre-update view of the table from a post-update one.

A long random mix then packs a dozen tags and a narrow address window together. This makes aliasing, replacement and eviction interleave. Every output is compared with a behavioural table model on every cycle.

// File: rtl/spec_load_table.sv
module spec_load_table #(
  parameter int ENTRIES   = 8,
  parameter int REG_W     = 7,
  parameter int ADDR_W    = 32,
  parameter int KIND_W    = 2,
  parameter bit RR_VICTIM = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_all,
  input  logic              alloc_valid,
  input  logic [REG_W-1:0]  alloc_reg,
  input  logic [1:0]        alloc_size,
  input  logic [KIND_W-1:0] alloc_kind,
  input  logic [ADDR_W-1:0] alloc_addr,
  input  logic              alloc_fault,
  input  logic              st_valid,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [1:0]        st_size,
  input  logic              chk_valid,
  input  logic [REG_W-1:0]  chk_reg,
  input  logic              chk_mode,
  output logic              chk_hit,
  output logic              chk_reissue,
  output logic              chk_recover,
  output logic [KIND_W-1:0] chk_kind,
  output logic [1:0]        chk_size,
  output logic              alloc_exc
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int EXT_W = ADDR_W + 1;

  logic [ENTRIES-1:0] valid_q, valid_d, kill, a_match, c_match;
  logic [REG_W-1:0]   tag_q  [ENTRIES];
  logic [ADDR_W-1:0]  addr_q [ENTRIES];
  logic [1:0]         size_q [ENTRIES];
  logic [KIND_W-1:0]  kind_q [ENTRIES];
  logic [IDX_W-1:0]   rr_q, free_idx, same_idx, victim, wr_idx;
  logic               free_found, evict, do_alloc;
  logic [EXT_W-1:0]   st_lo, st_end;

  assign st_lo  = {1'b0, st_addr};
  assign st_end = st_lo + (EXT_W'(1) << st_size);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic [EXT_W-1:0] e_lo, e_end;
    assign e_lo       = {1'b0, addr_q[g]};
    assign e_end      = e_lo + (EXT_W'(1) << size_q[g]);
    assign kill[g]    = st_valid & valid_q[g] & (st_lo < e_end) & (e_lo < st_end);
    assign a_match[g] = valid_q[g] & (tag_q[g] == alloc_reg);
    assign c_match[g] = valid_q[g] & (tag_q[g] == chk_reg);
  end

  always_comb begin
    free_found = 1'b0;
    free_idx   = '0;
    same_idx   = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!valid_q[i]) begin
        free_found = 1'b1;
        free_idx   = IDX_W'(i);
      end
    for (int i = 0; i < ENTRIES; i++)
      if (a_match[i]) same_idx = IDX_W'(i);
  end

  assign victim   = RR_VICTIM ? rr_q : IDX_W'(ENTRIES - 1);
  assign evict    = ~|a_match & ~free_found;
  assign wr_idx   = |a_match ? same_idx : (free_found ? free_idx : victim);
  assign do_alloc = alloc_valid & ~alloc_fault;

  always_comb begin
    valid_d = flush_all ? '0 : (valid_q & ~kill);
    if (do_alloc) valid_d[wr_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      valid_q <= '0;
      rr_q    <= '0;
    end else begin
      valid_q <= valid_d;
      if (do_alloc && evict && RR_VICTIM)
        rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + IDX_W'(1);
    end

  always_ff @(posedge clk)
    if (do_alloc) begin
      tag_q[wr_idx]  <= alloc_reg;
      addr_q[wr_idx] <= alloc_addr;
      size_q[wr_idx] <= alloc_size;
      kind_q[wr_idx] <= alloc_kind;
    end

  always_comb begin
    chk_kind = '0;
    chk_size = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (c_match[i]) begin
        chk_kind = chk_kind | kind_q[i];
        chk_size = chk_size | size_q[i];
      end
  end

  assign chk_hit     = chk_valid & |c_match;
  assign chk_reissue = chk_valid & ~|c_match & ~chk_mode;
  assign chk_recover = chk_valid & ~|c_match & chk_mode;
  assign alloc_exc   = alloc_valid & alloc_fault;

  // R2
  tag_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(c_match));

  // R3
  chk_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({chk_hit, chk_reissue, chk_recover}) &&
    (chk_valid == (chk_hit | chk_reissue | chk_recover)));

  // R9
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all && !alloc_valid |=> valid_q == '0);

  // R7
  fault_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_valid && alloc_fault && !st_valid && !flush_all |=> $stable(valid_q));

  // R8
  chk_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid && !alloc_valid && !st_valid && !flush_all |=> $stable(valid_q));

  // R10
  alloc_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_valid && !alloc_fault |=> $countones(valid_q) >= 1);
endmodule

// File: tb/spec_load_table_tb.sv
module spec_load_table_tb;
  localparam int N = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic flush_all = 0, alloc_valid = 0, alloc_fault = 0, st_valid = 0, chk_valid = 0, chk_mode = 0;
  logic [6:0]  alloc_reg = 0, chk_reg = 0;
  logic [1:0]  alloc_size = 0, st_size = 0, chk_size;
  logic [1:0]  alloc_kind = 0, chk_kind;
  logic [31:0] alloc_addr = 0, st_addr = 0;
  logic chk_hit, chk_reissue, chk_recover, alloc_exc;

  int checks = 0, errors = 0;
  bit done = 0;
  bit m_v [N];
  int m_reg [N], m_size [N], m_kind [N], m_ptr;
  longint m_addr [N];

  spec_load_table u_dut (
    .clk(clk), .rst_n(rst_n), .flush_all(flush_all),
    .alloc_valid(alloc_valid), .alloc_reg(alloc_reg), .alloc_size(alloc_size),
    .alloc_kind(alloc_kind), .alloc_addr(alloc_addr), .alloc_fault(alloc_fault),
    .st_valid(st_valid), .st_addr(st_addr), .st_size(st_size),
    .chk_valid(chk_valid), .chk_reg(chk_reg), .chk_mode(chk_mode),
    .chk_hit(chk_hit), .chk_reissue(chk_reissue), .chk_recover(chk_recover),
    .chk_kind(chk_kind), .chk_size(chk_size), .alloc_exc(alloc_exc));

  always #5 clk = ~clk;

  task automatic cmp(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit ovl(longint a, int sa, longint b, int sb);
    return (a < b + (1 << sb)) && (b < a + (1 << sa));
  endfunction

  task automatic step(bit fl, bit av, int ar, int asz, int ak, longint aa, bit af,
                      bit sv, longint sa, int ssz, bit cv, int cr, bit cm, string req);
    int hit_j, same_j, free_j, w;
    flush_all = fl; alloc_valid = av; alloc_reg = 7'(ar); alloc_size = 2'(asz);
    alloc_kind = 2'(ak); alloc_addr = 32'(aa); alloc_fault = af;
    st_valid = sv; st_addr = 32'(sa); st_size = 2'(ssz);
    chk_valid = cv; chk_reg = 7'(cr); chk_mode = cm;
    #2;
    hit_j = -1;
    for (int i = 0; i < N; i++) if (m_v[i] && m_reg[i] == cr) hit_j = i;
    cmp(req, "hit", int'(chk_hit), int'(cv && hit_j >= 0));
    cmp(req, "reissue", int'(chk_reissue), int'(cv && hit_j < 0 && !cm));
    cmp(req, "recover", int'(chk_recover), int'(cv && hit_j < 0 && cm));
    cmp(req, "exc", int'(alloc_exc), int'(av && af));
    if (cv && hit_j >= 0) begin
      cmp(req, "kind", int'(chk_kind), m_kind[hit_j]);
      cmp(req, "size", int'(chk_size), m_size[hit_j]);
    end
    @(posedge clk);
    same_j = -1; free_j = -1;
    for (int i = 0; i < N; i++) if (m_v[i] && m_reg[i] == ar) same_j = i;
    for (int i = N - 1; i >= 0; i--) if (!m_v[i]) free_j = i;
    for (int i = 0; i < N; i++) begin
      if (fl) m_v[i] = 0;
      else if (sv && m_v[i] && ovl(m_addr[i], m_size[i], sa, ssz)) m_v[i] = 0;
    end
    if (av && !af) begin
      if (same_j >= 0) w = same_j;
      else if (free_j >= 0) w = free_j;
      else begin w = m_ptr; m_ptr = (m_ptr + 1) % N; end
      m_v[w] = 1; m_reg[w] = ar; m_addr[w] = aa; m_size[w] = asz; m_kind[w] = ak;
    end
    @(negedge clk);
  endtask

  task automatic idle(); step(0,0,0,0,0,0,0, 0,0,0, 0,0,0, "idle"); endtask
  task automatic al(int r, int sz, int k, longint a, string req);
    step(0,1,r,sz,k,a,0, 0,0,0, 0,0,0, req);
  endtask
  task automatic st(longint a, int sz, string req); step(0,0,0,0,0,0,0, 1,a,sz, 0,0,0, req); endtask
  task automatic ck(int r, bit m, string req); step(0,0,0,0,0,0,0, 0,0,0, 1,r,m, req); endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) m_v[i] = 0;
    m_ptr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    ck(5, 0, "R1"); ck(5, 1, "R1");
    al(5, 2, 1, 'h100, "R2"); ck(5, 0, "R2");
    st('h104, 2, "R4"); ck(5, 1, "R4");
    st('hFC, 2, "R4"); ck(5, 1, "R4");
    st('h103, 1, "R4"); ck(5, 1, "R4"); ck(5, 0, "R3");
    al(5, 0, 3, 'h200, "R5"); al(5, 3, 2, 'h300, "R5");
    st('h200, 3, "R5"); ck(5, 0, "R5");
    st('h307, 0, "R5"); ck(5, 0, "R5");
    step(0,1,7,2,1,'h400,1, 0,0,0, 0,0,0, "R7"); ck(7, 1, "R7");
    step(1,1,20,2,1,'h1000,0, 0,0,0, 0,0,0, "R9");
    ck(5, 1, "R9"); ck(20, 0, "R9");
    for (int i = 1; i < N; i++) al(20 + i, 2, i % 4, 'h1000 + 16 * i, "R6");
    al(30, 1, 2, 'h2000, "R6"); ck(20, 1, "R6"); ck(21, 0, "R6");
    al(31, 1, 2, 'h2010, "R6"); ck(21, 1, "R6"); ck(22, 0, "R6");
    ck(22, 0, "R8"); ck(22, 1, "R8");
    step(0,1,40,2,3,'h1020,0, 1,'h1020,2, 0,0,0, "R10");
    ck(22, 0, "R10"); ck(40, 0, "R10");
    step(0,0,0,0,0,0,0, 1,'h1030,0, 1,23,1, "R11");
    ck(23, 1, "R11");
    idle();
    for (int n = 0; n < 3000; n++) begin
      bit fl = ($urandom % 40) == 0;
      bit av = ($urandom % 2) == 0;
      bit af = ($urandom % 12) == 0;
      bit sv = ($urandom % 3) == 0;
      bit cv = ($urandom % 2) == 0;
      step(fl, av, $urandom % 12, $urandom % 4, $urandom % 4, 'h40 + $urandom % 48, af,
           sv, 'h40 + $urandom % 48, $urandom % 4, cv, $urandom % 12, 1'($urandom % 2), "RND-R6");
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule